// File: doc/BRIEF.md
# Two-Lane Binomial Noise-Suppression FIR

This block sits between a two-lane noise-shaping modulator that runs at half the sample rate and the 2:1 multiplexer that interleaves its lanes into a full-rate stream. It applies the low-pass response (1 + z^-1)^m to the interleaved sample stream. All m zeros of that response fall at half the sample rate. This removes the shaped high-frequency noise that a duty-cycle error on the half-rate clock would otherwise fold back into the signal band.

Each clock carries two consecutive samples of the stream: the even lane holds the earlier one and the odd lane the later one. When the valid strobe is high, the block produces two filtered samples. The coefficients are binomial (1; 1 1; 1 2 1; 1 3 3 1). They are formed only from shifted copies of the taps and adders, with no multipliers. Codes are unsigned. The output is exactly m bits wider than the input, and because the coefficients sum to 2^m, a full-scale input never overflows.

Top module: `duo_binomial_fir`

## Requirements
- R1: A synchronous active-low reset sets both output lanes to zero and out_valid low, and clears the sample history to zero, so the first valid pair after reset sees zeros as its earlier samples.
- R2: out_valid equals in_valid of the previous clock; each output pair appears exactly one clock after its input pair.
- R3: A full-scale input (all ones on both lanes, held long enough to fill the history) gives (2^IN_W - 1) * 2^ORDER on both lanes, with no wrap.
- R4: With ORDER = 3, the odd-lane output is x_odd + 3*x_even + 3*p_odd + p_even. Here x is the current pair and p is the most recent earlier pair.
- R5: With ORDER = 3, the even-lane output is x_even + 3*p_odd + 3*p_even + q_odd, where q is the pair before p. Only the current even sample is taken from the present cycle.
- R6: A clock with in_valid low has no effect: both output lanes hold their values and the history does not advance, whatever the data inputs carry.
- R7: A stream alternating A, 0, A, 0 (even lane A, odd lane 0) settles to 2^(ORDER-1) * A on both lanes, because the zeros at half the sample rate remove the alternating part.
- R8: The output lanes are IN_W + ORDER bits wide.
- R9: With ORDER = 0, each output lane equals its input lane delayed by one valid clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pair is valid this clock |
| in_even | input | IN_W | Earlier sample of the pair |
| in_odd | input | IN_W | Later sample of the pair |
| out_valid | output | 1 | Output pair is valid |
| out_even | output | IN_W+ORDER | Filtered earlier sample |
| out_odd | output | IN_W+ORDER | Filtered later sample |

## Verification
The hardest case to reach is the even lane, whose delayed terms span two earlier clocks, across a gap in the valid strobe. A wrong history update there stays hidden until the next valid pair, and only when the older samples differ. The stimulus therefore feeds distinct values on both lanes, inserts invalid clocks carrying unrelated data, and then resumes. A reference model that tracks the stream history compares both lanes on every clock. Separate full-scale and alternating sequences expose overflow and errors at half the sample rate.

// File: rtl/binfir_pkg.sv
// Shared constants and the compile-time coefficient function for the
// two-lane binomial FIR. Assumes orders stay small (0..3).
package binfir_pkg;

    localparam int unsigned MAX_ORDER = 3;

    // Binomial coefficient n choose k, evaluated at elaboration only.
    function automatic int unsigned binom(input int unsigned n, input int unsigned k);
        int unsigned r;
        r = 1;
        for (int unsigned i = 0; i < k; i++) begin
            r = (r * (n - i)) / (i + 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/binfir_history.sv
// Sample history for the interleaved stream. It stores the DEPTH most
// recent samples, newest first (index 0 = last odd sample, index 1 = last
// even sample, and so on). It advances by two samples on each valid clock.
// Assumes DEPTH >= 1.
module binfir_history #(
    parameter int IN_W  = 8,
    parameter int DEPTH = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        adv,
    input  logic [IN_W-1:0]             s_even,
    input  logic [IN_W-1:0]             s_odd,
    output logic [DEPTH-1:0][IN_W-1:0]  past
);

    // Newest slot: takes the odd sample of an accepted pair.
    always_ff @(posedge clk) begin
        if (!rst_n)   past[0] <= '0;
        else if (adv) past[0] <= s_odd;
    end

    genvar j;
    generate
        if (DEPTH > 1) begin : g_second
            // Second slot: takes the even sample of an accepted pair.
            always_ff @(posedge clk) begin
                if (!rst_n)   past[1] <= '0;
                else if (adv) past[1] <= s_even;
            end
        end
        for (j = 2; j < DEPTH; j++) begin : g_older
            // Older slots: shift by two samples per accepted pair.
            always_ff @(posedge clk) begin
                if (!rst_n)   past[j] <= '0;
                else if (adv) past[j] <= past[j-2];
            end
        end
    endgenerate

endmodule

// File: rtl/binfir_tapsum.sv
// Weighted sum of ORDER+1 taps using binomial weights. Each weight is
// built from shifted copies of the tap, so no multiplier is inferred.
// taps[0] is the newest sample. The result is IN_W+ORDER bits wide and
// cannot overflow, because the weights sum to 2^ORDER.
module binfir_tapsum
    import binfir_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int ORDER = 3
) (
    input  logic [ORDER:0][IN_W-1:0]  taps,
    output logic [IN_W+ORDER-1:0]     sum
);

    localparam int OUT_W = IN_W + ORDER;

    // Shift-and-add accumulation over the constant weight bits.
    always_comb begin
        sum = '0;
        for (int i = 0; i <= ORDER; i++) begin
            for (int b = 0; b <= ORDER; b++) begin
                if (((binom(ORDER, i) >> b) & 1) != 0) begin
                    sum = sum + (OUT_W'(taps[i]) << b);
                end
            end
        end
    end

endmodule

// File: rtl/duo_binomial_fir.sv
// Two-lane polyphase binomial FIR (1 + z^-1)^ORDER. Each clock takes an
// even/odd pair of consecutive samples and, when in_valid is high,
// registers two filtered samples one clock later. The odd lane uses the
// current even sample as its first delayed term; the even lane draws its
// delayed terms from the stored history. Assumes ORDER in 0..3, unsigned codes.
module duo_binomial_fir
    import binfir_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int ORDER = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [IN_W-1:0]         in_even,
    input  logic [IN_W-1:0]         in_odd,
    output logic                    out_valid,
    output logic [IN_W+ORDER-1:0]   out_even,
    output logic [IN_W+ORDER-1:0]   out_odd
);

    localparam int OUT_W = IN_W + ORDER;
    localparam int WIN_N = ORDER + 2;

    logic [WIN_N-1:0][IN_W-1:0] win;
    logic [OUT_W-1:0]           sum_even;
    logic [OUT_W-1:0]           sum_odd;

    // Current pair forms the two newest window slots.
    always_comb begin
        win[0] = in_odd;
        win[1] = in_even;
    end

    generate
        if (ORDER > 0) begin : g_hist
            logic [ORDER-1:0][IN_W-1:0] past;

            binfir_history #(.IN_W(IN_W), .DEPTH(ORDER)) u_hist (
                .clk    (clk),
                .rst_n  (rst_n),
                .adv    (in_valid),
                .s_even (in_even),
                .s_odd  (in_odd),
                .past   (past)
            );

            // Stored samples fill the older window slots.
            always_comb begin
                for (int j = 0; j < ORDER; j++) begin
                    win[j+2] = past[j];
                end
            end
        end
    endgenerate

    binfir_tapsum #(.IN_W(IN_W), .ORDER(ORDER)) u_sum_odd (
        .taps (win[ORDER:0]),
        .sum  (sum_odd)
    );

    binfir_tapsum #(.IN_W(IN_W), .ORDER(ORDER)) u_sum_even (
        .taps (win[ORDER+1:1]),
        .sum  (sum_even)
    );

    // Output registers: load on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_even <= '0;
            out_odd  <= '0;
        end else if (in_valid) begin
            out_even <= sum_even;
            out_odd  <= sum_odd;
        end
    end

    // Valid strobe tracks the input strobe with one clock of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

endmodule

// File: rtl/duo_binomial_fir_chk.sv
// Property checker for duo_binomial_fir, attached by bind. It observes
// ports only and relates them over time.
module duo_binomial_fir_chk #(
    parameter int IN_W  = 8,
    parameter int ORDER = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [IN_W-1:0]         in_even,
    input  logic [IN_W-1:0]         in_odd,
    input  logic                    out_valid,
    input  logic [IN_W+ORDER-1:0]   out_even,
    input  logic [IN_W+ORDER-1:0]   out_odd
);

    localparam int CW = IN_W + ORDER + 1;

    // R1: reset clears outputs on the following clock
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_even == '0 && out_odd == '0));

    // R2: strobe follows one clock later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R6: idle clock leaves both lanes unchanged
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_even) && $stable(out_odd)));

    generate
        if (ORDER > 0) begin : g_taps
            // R4: odd lane covers the current pair (weights are at least 1)
            a_r4_odd_covers_pair: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> (CW'(out_odd) >= CW'($past(in_odd)) + CW'($past(in_even))));

            // R5: even lane includes the odd sample of the previous pair
            a_r5_even_uses_prev: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && rst_n) ##1 in_valid |=>
                    (CW'(out_even) >= CW'($past(in_odd, 2)) + CW'($past(in_even))));
        end
    endgenerate

endmodule

bind duo_binomial_fir duo_binomial_fir_chk #(.IN_W(IN_W), .ORDER(ORDER)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_even   (in_even),
    .in_odd    (in_odd),
    .out_valid (out_valid),
    .out_even  (out_even),
    .out_odd   (out_odd)
);

// File: tb/tb_duo_binomial_fir.sv
module tb_duo_binomial_fir;

    localparam int IN_W  = 8;
    localparam int ORDER = 3;
    localparam int OUT_W = IN_W + ORDER;
    localparam int CLK_NS = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [IN_W-1:0] in_even = '0;
    logic [IN_W-1:0] in_odd  = '0;
    logic out_valid, p_valid;
    logic [OUT_W-1:0] out_even, out_odd;
    logic [IN_W-1:0]  p_even, p_odd;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    string tag = "R1";

    // Reference state (model of the stream, newest sample first)
    int hist[$];
    int exp_v = 0, exp_e = 0, exp_o = 0;
    int exp_pv = 0, exp_pe = 0, exp_po = 0;

    always #(CLK_NS/2) clk = ~clk;

    duo_binomial_fir #(.IN_W(IN_W), .ORDER(ORDER)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_even(in_even), .in_odd(in_odd),
        .out_valid(out_valid), .out_even(out_even), .out_odd(out_odd)
    );

    duo_binomial_fir #(.IN_W(IN_W), .ORDER(0)) dut_pass (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_even(in_even), .in_odd(in_odd),
        .out_valid(p_valid), .out_even(p_even), .out_odd(p_odd)
    );

    function automatic int choose(int n, int k);
        int r = 1;
        for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
        return r;
    endfunction

    task automatic chk(string t, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
        end
    endtask

    task automatic model_reset();
        hist.delete();
        for (int i = 0; i < 8; i++) hist.push_back(0);
        exp_v = 0; exp_e = 0; exp_o = 0;
        exp_pv = 0; exp_pe = 0; exp_po = 0;
    endtask

    // Advance the reference by one clock with the given inputs
    task automatic model_step(bit v, int e, int o);
        int w[$];
        exp_v = v; exp_pv = v;
        if (!v) return;
        w = hist;
        w.push_front(e);
        w.push_front(o);
        exp_o = 0; exp_e = 0;
        for (int i = 0; i <= ORDER; i++) begin
            exp_o += choose(ORDER, i) * w[i];
            exp_e += choose(ORDER, i) * w[i+1];
        end
        exp_pe = e; exp_po = o;
        hist.push_front(e);
        hist.push_front(o);
        void'(hist.pop_back());
        void'(hist.pop_back());
    endtask

    // Compare all outputs against the model at the falling edge
    task automatic compare_all();
        chk(tag, "out_valid", int'(out_valid), exp_v);
        chk(tag, "out_even",  int'(out_even),  exp_e);
        chk(tag, "out_odd",   int'(out_odd),   exp_o);
        chk("R9", "pass valid", int'(p_valid), exp_pv);
        chk("R9", "pass even",  int'(p_even),  exp_pe);
        chk("R9", "pass odd",   int'(p_odd),   exp_po);
    endtask

    task automatic cyc(bit v, int e, int o);
        @(negedge clk);
        compare_all();
        in_valid = v;
        in_even  = IN_W'(e);
        in_odd   = IN_W'(o);
        model_step(v, e, o);
    endtask

    initial begin
        int full;
        model_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        tag = "R1";
        chk("R1", "out_even after reset", int'(out_even), 0);
        chk("R1", "out_odd after reset",  int'(out_odd),  0);
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        rst_n = 1'b1;

        // R8: widths
        chk("R8", "output width", $bits(out_even), IN_W + ORDER);

        // R1/R4/R5: first pairs after reset see zero history
        tag = "R4";
        cyc(1, 10, 20);
        cyc(1, 1, 2);
        cyc(0, 0, 0);
        // hand values: pair(10,20) then pair(1,2)
        chk("R4", "odd lane hand value", int'(out_odd), 2 + 3*1 + 3*20 + 10);
        chk("R5", "even lane hand value", int'(out_even), 1 + 3*20 + 3*10 + 0);

        // R6: invalid clocks with unrelated data, then resume
        tag = "R6";
        cyc(0, 255, 255);
        cyc(0, 77, 133);
        cyc(0, 9, 250);
        cyc(1, 40, 50);
        cyc(1, 60, 70);
        tag = "R5";
        cyc(0, 0, 0);
        chk("R5", "even lane after gap", int'(out_even), 60 + 3*50 + 3*40 + 2);

        // R3: full scale
        tag = "R3";
        full = ((1 << IN_W) - 1) * (1 << ORDER);
        repeat (3) cyc(1, (1 << IN_W) - 1, (1 << IN_W) - 1);
        cyc(0, 0, 0);
        chk("R3", "full-scale even", int'(out_even), full);
        chk("R3", "full-scale odd",  int'(out_odd),  full);

        // R7: alternating stream at half the sample rate
        tag = "R7";
        repeat (3) cyc(1, 200, 0);
        cyc(0, 0, 0);
        chk("R7", "alternating even", int'(out_even), 200 * (1 << (ORDER-1)));
        chk("R7", "alternating odd",  int'(out_odd),  200 * (1 << (ORDER-1)));

        // R2: strobe latency under irregular valid patterns
        tag = "R2";
        for (int n = 0; n < 300; n++) begin
            cyc(($urandom % 3) != 0, $urandom % 256, $urandom % 256);
        end

        // R1: reset mid-stream clears history
        tag = "R1";
        @(negedge clk);
        compare_all();
        in_valid = 1'b0;
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        compare_all();
        rst_n = 1'b1;
        cyc(1, 5, 6);
        cyc(0, 0, 0);
        chk("R1", "odd after mid reset", int'(out_odd), 6 + 3*5);
        chk("R1", "even after mid reset", int'(out_even), 5);
        @(negedge clk);
        compare_all();

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule